// File: doc/BRIEF.md
# One-Hot Bounded-Delay Sequence Matcher

This block recognises a fixed temporal pattern on a group of single-bit terms. An attempt opens in a cycle where the start trigger and `term0In` are both high. After a delay of d cycles it needs `term1In`. It then needs `term2In` in each of the next k consecutive cycles. The allowed range of d and the allowed range of k are set at elaboration time. Each upper bound can also be made unbounded.

Every state of the underlying nondeterministic automaton is its own flip-flop. Any number of attempts can therefore be in flight at once, and attempts that meet on the same state merge without interfering. Optional delay stages and optional repetition copies are skipped by same-cycle links. The match output pulses in the very cycle the last `term2In` is seen.

Two inputs gate every transition and every link. A kill input wipes out all attempts in progress. A qualifier input must stay high for the whole duration of an attempt. The block has no reset: all state comes up empty at power-up.

Top module: `seqMatcher`

## Requirements
- R1: `matchOut` is high in the same cycle as the last required `term2In` for any attempt formed as follows. `trigIn` and `term0In` are high at cycle s, `term1In` is high at cycle s+d, and `term2In` is high in each of cycles s+d+1 to s+d+k. All signals are active high.
- R2: With `DLY_OPEN`=0, an attempt matches only when `DLY_MIN` ≤ d ≤ `DLY_MAX`. A `term1In` seen at any other distance from the start does not complete that attempt.
- R3: With `DLY_OPEN`=1, any d ≥ `DLY_MIN` is accepted, however long the wait is.
- R4: With `REP_OPEN`=0, `term2In` must be high in k consecutive cycles with `REP_MIN` ≤ k ≤ `REP_MAX`. An attempt yields a match only in the cycles where its run length falls in that range. A gap in the run ends the attempt.
- R5: With `REP_OPEN`=1, an attempt yields a match in every cycle from its `REP_MIN`-th consecutive `term2In` onward, for as long as `term2In` stays high.
- R6: An attempt begins only in a cycle where `trigIn` is high. A `term0In` without the trigger starts nothing.
- R7: A cycle with `killIn` high forces `matchOut` low and discards every attempt in progress. Attempts that begin after that cycle work normally.
- R8: `qualIn` must be high in every cycle from the start of an attempt to its match cycle. Any cycle with `qualIn` low drops all attempts and forces `matchOut` low.
- R9: Overlapping attempts are tracked independently. `matchOut` is high whenever at least one attempt completes in that cycle.
- R10: At power-up no attempt is pending, and `matchOut` stays low until an attempt completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| trigIn | input | 1 | Start trigger; high lets an attempt open this cycle |
| killIn | input | 1 | Kill; high discards every attempt in progress |
| qualIn | input | 1 | Qualifier; must hold high for an attempt to survive |
| term0In | input | 1 | First term of the pattern |
| term1In | input | 1 | Term expected after the delay |
| term2In | input | 1 | Repeated final term |
| matchOut | output | 1 | High in the cycle an attempt completes |

## Verification
The hardest state to reach is many live attempts at once. Starts a few cycles apart share one `term1In` and then fan out over several repetition counts, so one merged one-hot state must stand for several histories. Dense random triggers and terms over thousands of cycles produce this often. A bench model enumerates every possible start cycle, so each output cycle is checked against all overlapping histories. Directed cases add a start followed by a twenty-cycle wait for the unbounded delay variant. They also add kills and qualifier drops in the middle and on the last cycle of an attempt.

// File: rtl/seqMatchPkg.sv
`timescale 1ns/1ps
package seqMatchPkg;

  // Strobes handed from the control module to the state datapath.
  typedef struct packed {
    logic armed;   // high from the first clock edge onward
    logic live;    // no kill this cycle: state activity may be seen
    logic step;    // qualifier high: transitions and links may fire
    logic launch;  // the start state counts as active this cycle
  } seqStrobeT;

endpackage

// File: rtl/seqCtrl.sv
`timescale 1ns/1ps
module seqCtrl
  import seqMatchPkg::*;
(
  input  logic      clk,
  input  logic      trigIn,
  input  logic      killIn,
  input  logic      qualIn,
  output seqStrobeT strobe
);

  logic armedQ = 1'b0;

  always_ff @(posedge clk) armedQ <= 1'b1;

  always_comb begin
    strobe.armed  = armedQ;
    strobe.live   = ~killIn;
    strobe.step   = qualIn;
    // The start state has no flip-flop: it is active exactly when triggered.
    strobe.launch = trigIn & ~killIn & qualIn;
  end

endmodule

// File: rtl/seqDelayLine.sv
`timescale 1ns/1ps
module seqDelayLine
  import seqMatchPkg::*;
#(
  parameter int DLY_MIN  = 1,
  parameter int DLY_MAX  = 3,
  parameter bit DLY_OPEN = 1'b0
) (
  input  logic      clk,
  input  seqStrobeT strobe,
  input  logic      term0In,
  input  logic      term1In,
  output logic      hitOut
);

  // Stage 0 is where term0 was seen; stage i is i cycles later.
  localparam int LAST = DLY_OPEN ? DLY_MIN : DLY_MAX;

  function automatic logic [LAST:0] calcFlopMask();
    logic [LAST:0] m;
    for (int i = 0; i <= LAST; i++) m[i] = (i > 0) || (DLY_OPEN && DLY_MIN == 0);
    return m;
  endfunction

  // Stages without an incoming edge are held at constant zero.
  localparam logic [LAST:0] FLOP_MASK = calcFlopMask();

  logic [LAST:0] stageQ = '0;
  logic [LAST:0] stageAct;
  logic [LAST:0] stageNext;

  always_comb begin
    stageAct[0]  = (stageQ[0] & strobe.live) | (strobe.launch & term0In);
    stageNext[0] = (DLY_OPEN && DLY_MIN == 0) ? (stageAct[0] & strobe.step) : 1'b0;
    for (int i = 1; i <= LAST; i++) begin
      stageAct[i] = stageQ[i] & strobe.live;
      // Optional stages are bypassed by a same-cycle link from the previous one.
      if (!DLY_OPEN && i > DLY_MIN) stageAct[i] = stageAct[i] | (stageAct[i-1] & strobe.step);
      stageNext[i] = stageAct[i-1] & strobe.step;
      // Unbounded delay: the minimum stage keeps itself alive.
      if (DLY_OPEN && i == DLY_MIN) stageNext[i] = stageNext[i] | (stageAct[i] & strobe.step);
    end
  end

  always_ff @(posedge clk) stageQ <= stageNext & FLOP_MASK;

  assign hitOut = stageAct[LAST] & term1In & strobe.step;

  a_r7_delay_flush: assert property (@(posedge clk) disable iff (!strobe.armed)
    !strobe.live |=> (stageQ == '0));

  a_r8_delay_flush: assert property (@(posedge clk) disable iff (!strobe.armed)
    !strobe.step |=> (stageQ == '0));

endmodule

// File: rtl/seqRepeatLine.sv
`timescale 1ns/1ps
module seqRepeatLine
  import seqMatchPkg::*;
#(
  parameter int REP_MIN  = 2,
  parameter int REP_MAX  = 3,
  parameter bit REP_OPEN = 1'b0
) (
  input  logic      clk,
  input  seqStrobeT strobe,
  input  logic      hitIn,
  input  logic      term2In,
  output logic      matchOut
);

  localparam int LAST = REP_OPEN ? REP_MIN : REP_MAX;

  // copyQ[i]: waiting to see the i-th term2; endAct[i]: i-th copy seen now.
  logic [LAST:1] copyQ = '0;
  logic          loopQ = 1'b0;
  logic [LAST:1] copyNext;
  logic [LAST:0] endAct;
  logic          loopAct;
  logic          loopNext;

  always_comb begin
    loopAct   = loopQ & strobe.live & term2In & strobe.step;
    endAct[0] = hitIn;
    for (int i = 1; i <= LAST; i++) begin
      endAct[i] = copyQ[i] & strobe.live & term2In & strobe.step;
      // Optional copies may be skipped through a link from the previous end.
      if (!REP_OPEN && i > REP_MIN) endAct[i] = endAct[i] | (endAct[i-1] & strobe.step);
      // Unbounded: an extra copy links back onto the minimum end.
      if (REP_OPEN && i == REP_MIN) endAct[i] = endAct[i] | (loopAct & strobe.step);
      copyNext[i] = endAct[i-1] & strobe.step;
    end
    loopNext = REP_OPEN ? (endAct[REP_MIN] & strobe.step) : 1'b0;
  end

  always_ff @(posedge clk) begin
    copyQ <= copyNext;
    loopQ <= loopNext;
  end

  generate
    if (REP_OPEN) begin : gOpenEnd
      assign matchOut = endAct[REP_MIN];
    end else begin : gBoundEnd
      assign matchOut = endAct[REP_MAX];
    end
  endgenerate

  a_r1_match_needs_term2: assert property (@(posedge clk) disable iff (!strobe.armed)
    matchOut |-> term2In);

  a_r7_no_match_on_kill: assert property (@(posedge clk) disable iff (!strobe.armed)
    !strobe.live |-> !matchOut);

  a_r8_no_match_unqualified: assert property (@(posedge clk) disable iff (!strobe.armed)
    !strobe.step |-> !matchOut);

  a_r7_repeat_flush: assert property (@(posedge clk) disable iff (!strobe.armed)
    !strobe.live |=> (copyQ == '0 && !loopQ));

endmodule

// File: rtl/seqDatapath.sv
`timescale 1ns/1ps
module seqDatapath
  import seqMatchPkg::*;
#(
  parameter int DLY_MIN  = 1,
  parameter int DLY_MAX  = 3,
  parameter bit DLY_OPEN = 1'b0,
  parameter int REP_MIN  = 2,
  parameter int REP_MAX  = 3,
  parameter bit REP_OPEN = 1'b0
) (
  input  logic      clk,
  input  seqStrobeT strobe,
  input  logic      term0In,
  input  logic      term1In,
  input  logic      term2In,
  output logic      matchOut
);

  logic term1Hit;

  seqDelayLine #(
    .DLY_MIN (DLY_MIN),
    .DLY_MAX (DLY_MAX),
    .DLY_OPEN(DLY_OPEN)
  ) i_delay (
    .clk    (clk),
    .strobe (strobe),
    .term0In(term0In),
    .term1In(term1In),
    .hitOut (term1Hit)
  );

  seqRepeatLine #(
    .REP_MIN (REP_MIN),
    .REP_MAX (REP_MAX),
    .REP_OPEN(REP_OPEN)
  ) i_repeat (
    .clk     (clk),
    .strobe  (strobe),
    .hitIn   (term1Hit),
    .term2In (term2In),
    .matchOut(matchOut)
  );

endmodule

// File: rtl/seqMatcher.sv
`timescale 1ns/1ps
module seqMatcher
  import seqMatchPkg::*;
#(
  parameter int DLY_MIN  = 1,
  parameter int DLY_MAX  = 3,
  parameter bit DLY_OPEN = 1'b0,
  parameter int REP_MIN  = 2,
  parameter int REP_MAX  = 3,
  parameter bit REP_OPEN = 1'b0
) (
  input  logic clk,
  input  logic trigIn,
  input  logic killIn,
  input  logic qualIn,
  input  logic term0In,
  input  logic term1In,
  input  logic term2In,
  output logic matchOut
);

  seqStrobeT strobe;

  seqCtrl i_ctrl (
    .clk   (clk),
    .trigIn(trigIn),
    .killIn(killIn),
    .qualIn(qualIn),
    .strobe(strobe)
  );

  seqDatapath #(
    .DLY_MIN (DLY_MIN),
    .DLY_MAX (DLY_MAX),
    .DLY_OPEN(DLY_OPEN),
    .REP_MIN (REP_MIN),
    .REP_MAX (REP_MAX),
    .REP_OPEN(REP_OPEN)
  ) i_datapath (
    .clk     (clk),
    .strobe  (strobe),
    .term0In (term0In),
    .term1In (term1In),
    .term2In (term2In),
    .matchOut(matchOut)
  );

endmodule

// File: tb/test_seqMatcher.sv
`timescale 1ns/1ps
module test_seqMatcher;

  localparam int MAXC = 4000;
  // Bounded instance: delay 1..3, repetition 2..3.
  localparam int BD_MIN = 1, BD_MAX = 3, BR_MIN = 2, BR_MAX = 3;
  // Open instance: delay 0.., repetition 1..
  localparam int OD_MIN = 0, OR_MIN = 1;

  logic clk = 1'b0;
  logic trigIn = 0, killIn = 0, qualIn = 1, term0In = 0, term1In = 0, term2In = 0;
  logic matchA, matchB;

  int testCount = 0;
  int failCount = 0;
  int cyc = 0;
  bit gotA, gotB;

  bit trH [MAXC];
  bit aH  [MAXC];
  bit bH  [MAXC];
  int okRun [MAXC];
  int t2Run [MAXC];

  always #5 clk = ~clk;

  seqMatcher #(.DLY_MIN(BD_MIN), .DLY_MAX(BD_MAX), .DLY_OPEN(1'b0),
               .REP_MIN(BR_MIN), .REP_MAX(BR_MAX), .REP_OPEN(1'b0)) i_seqMatcher (
    .clk(clk), .trigIn(trigIn), .killIn(killIn), .qualIn(qualIn),
    .term0In(term0In), .term1In(term1In), .term2In(term2In), .matchOut(matchA));

  seqMatcher #(.DLY_MIN(OD_MIN), .DLY_MAX(OD_MIN), .DLY_OPEN(1'b1),
               .REP_MIN(OR_MIN), .REP_MAX(OR_MIN), .REP_OPEN(1'b1)) i_seqMatcher_open (
    .clk(clk), .trigIn(trigIn), .killIn(killIn), .qualIn(qualIn),
    .term0In(term0In), .term1In(term1In), .term2In(term2In), .matchOut(matchB));

  // Enumerate every start cycle inside the current qualified run ending at e.
  function automatic bit refMatch(int e, int dMin, int dMax, bit dOpen,
                                  int rMin, int rMax, bit rOpen);
    if (okRun[e] == 0) return 1'b0;
    for (int s = e - okRun[e] + 1; s <= e; s++) begin
      if (trH[s] && aH[s]) begin
        for (int c1 = s + dMin; c1 <= e - rMin; c1++) begin
          if (!dOpen && (c1 - s) > dMax) break;
          if (bH[c1]) begin
            if ((rOpen || (e - c1) <= rMax) && t2Run[e] >= (e - c1)) return 1'b1;
          end
        end
      end
    end
    return 1'b0;
  endfunction

  task automatic check(input string tag, input bit got, input bit exp, input string what);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s %s cyc=%0d got=%0b exp=%0b", tag, what, cyc - 1, got, exp);
    end
  endtask

  task automatic step(input bit tr, input bit a, input bit b, input bit c,
                      input bit k, input bit q, input string tag);
    @(posedge clk);
    #1;
    trigIn = tr; term0In = a; term1In = b; term2In = c; killIn = k; qualIn = q;
    trH[cyc] = tr; aH[cyc] = a; bH[cyc] = b;
    okRun[cyc] = (q && !k) ? ((cyc > 0 ? okRun[cyc-1] : 0) + 1) : 0;
    t2Run[cyc] = c ? ((cyc > 0 ? t2Run[cyc-1] : 0) + 1) : 0;
    @(negedge clk);
    gotA = matchA;
    gotB = matchB;
    cyc++;
    check(tag, gotA, refMatch(cyc-1, BD_MIN, BD_MAX, 1'b0, BR_MIN, BR_MAX, 1'b0), "bounded-model");
    check(tag, gotB, refMatch(cyc-1, OD_MIN, 0, 1'b1, OR_MIN, 0, 1'b1), "open-model");
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic flush(input string tag);
    step(0, 0, 0, 0, 1, 1, tag);
  endtask

  initial begin
    #(200000 * 10);
    failCount++;
    $display("FAIL R9 watchdog expired got=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    // R10: power-up state, before any clock edge
    check("R10", matchA, 1'b0, "bounded-powerup");
    check("R10", matchB, 1'b0, "open-powerup");
    idle(3, "R10");

    // R1: start, term1 after 1, two term2 -> bounded match on second term2
    step(1, 1, 0, 0, 0, 1, "R1");
    step(0, 0, 1, 0, 0, 1, "R1");
    step(0, 0, 0, 1, 0, 1, "R1");
    check("R1", gotA, 1'b0, "bounded-one-copy");
    check("R1", gotB, 1'b1, "open-one-copy");
    step(0, 0, 0, 1, 0, 1, "R1");
    check("R1", gotA, 1'b1, "bounded-two-copies");
    flush("R1");

    // R2: delay at the maximum
    step(1, 1, 0, 0, 0, 1, "R2");
    idle(2, "R2");
    step(0, 0, 1, 0, 0, 1, "R2");
    step(0, 0, 0, 1, 0, 1, "R2");
    step(0, 0, 0, 1, 0, 1, "R2");
    check("R2", gotA, 1'b1, "bounded-delay-max");
    flush("R2");
    // R2: delay one past the maximum
    step(1, 1, 0, 0, 0, 1, "R2");
    idle(3, "R2");
    step(0, 0, 1, 0, 0, 1, "R2");
    step(0, 0, 0, 1, 0, 1, "R2");
    step(0, 0, 0, 1, 0, 1, "R2");
    check("R2", gotA, 1'b0, "bounded-delay-too-long");
    flush("R2");
    // R2: zero delay is below the bounded minimum
    step(1, 1, 1, 0, 0, 1, "R2");
    step(0, 0, 0, 1, 0, 1, "R2");
    step(0, 0, 0, 1, 0, 1, "R2");
    check("R2", gotA, 1'b0, "bounded-delay-zero");
    check("R2", gotB, 1'b1, "open-delay-zero");
    flush("R2");

    // R4: repetition count too many and a gap
    step(1, 1, 0, 0, 0, 1, "R4");
    step(0, 0, 1, 0, 0, 1, "R4");
    step(0, 0, 0, 1, 0, 1, "R4");
    step(0, 0, 0, 1, 0, 1, "R4");
    check("R4", gotA, 1'b1, "bounded-k2");
    step(0, 0, 0, 1, 0, 1, "R4");
    check("R4", gotA, 1'b1, "bounded-k3");
    step(0, 0, 0, 1, 0, 1, "R4");
    check("R4", gotA, 1'b0, "bounded-k4");
    flush("R4");
    step(1, 1, 0, 0, 0, 1, "R4");
    step(0, 0, 1, 0, 0, 1, "R4");
    step(0, 0, 0, 1, 0, 1, "R4");
    step(0, 0, 0, 0, 0, 1, "R4");
    step(0, 0, 0, 1, 0, 1, "R4");
    check("R4", gotA, 1'b0, "bounded-gap");
    flush("R4");

    // R6: no trigger, nothing starts
    step(0, 1, 0, 0, 0, 1, "R6");
    step(0, 0, 1, 0, 0, 1, "R6");
    step(0, 0, 0, 1, 0, 1, "R6");
    step(0, 0, 0, 1, 0, 1, "R6");
    check("R6", gotA, 1'b0, "bounded-no-trigger");
    check("R6", gotB, 1'b0, "open-no-trigger");
    flush("R6");

    // R7: kill in the final cycle, then a fresh attempt right after
    step(1, 1, 0, 0, 0, 1, "R7");
    step(0, 0, 1, 0, 0, 1, "R7");
    step(0, 0, 0, 1, 0, 1, "R7");
    step(0, 0, 0, 1, 1, 1, "R7");
    check("R7", gotA, 1'b0, "bounded-kill-last");
    check("R7", gotB, 1'b0, "open-kill-last");
    step(1, 1, 0, 0, 0, 1, "R7");
    step(0, 0, 1, 0, 0, 1, "R7");
    step(0, 0, 0, 1, 0, 1, "R7");
    step(0, 0, 0, 1, 0, 1, "R7");
    check("R7", gotA, 1'b1, "bounded-after-kill");
    flush("R7");

    // R8: qualifier drop in the middle of the delay
    step(1, 1, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 1, 0, 0, 1, "R8");
    step(0, 0, 0, 1, 0, 1, "R8");
    step(0, 0, 0, 1, 0, 1, "R8");
    check("R8", gotA, 1'b0, "bounded-qual-drop");
    check("R8", gotB, 1'b0, "open-qual-drop");
    flush("R8");

    // R9: two overlapping starts sharing and splitting term1
    step(1, 1, 0, 0, 0, 1, "R9");
    step(1, 1, 0, 0, 0, 1, "R9");
    step(0, 0, 1, 0, 0, 1, "R9");
    step(0, 0, 1, 1, 0, 1, "R9");
    step(0, 0, 0, 1, 0, 1, "R9");
    check("R9", gotA, 1'b1, "bounded-overlap-first");
    step(0, 0, 0, 1, 0, 1, "R9");
    check("R9", gotA, 1'b1, "bounded-overlap-second");
    flush("R9");

    // R3 and R5: long wait then a repeating tail on the open instance
    step(1, 1, 0, 0, 0, 1, "R3");
    idle(20, "R3");
    step(0, 0, 1, 0, 0, 1, "R3");
    step(0, 0, 0, 1, 0, 1, "R3");
    check("R3", gotB, 1'b1, "open-long-wait");
    check("R2", gotA, 1'b0, "bounded-long-wait");
    step(0, 0, 0, 1, 0, 1, "R5");
    check("R5", gotB, 1'b1, "open-k2");
    step(0, 0, 0, 1, 0, 1, "R5");
    check("R5", gotB, 1'b1, "open-k3");
    step(0, 0, 0, 0, 0, 1, "R5");
    check("R5", gotB, 1'b0, "open-tail-ends");
    flush("R5");

    // R9: dense random traffic against the enumerating model
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) == 0, ($urandom % 2) == 0, ($urandom % 3) == 0,
           ($urandom % 3) != 0, ($urandom % 20) == 0, ($urandom % 10) != 0, "R9");
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule